// File: doc/BRIEF.md
# Load-Use Interlock Unit

This block guards a five-stage integer pipeline against the single hazard that forwarding cannot cover: an instruction in decode that needs a register a load in execute has not fetched yet. It owns the two instruction-word pipeline registers between fetch and execute, the decode slot and the execute slot. Each cycle it classifies the decode-slot opcode, compares the register fields that class reads against the load's destination, and raises a one-cycle stall when they match.

During a stall the unit holds the program counter and the decode slot. It also loads an all-zero word, the no-operation encoding, into the execute slot, so the dependent instruction is offered again one cycle later. By then the load has moved on and forwarding can cover it. Consumers two slots behind a load are left to forwarding, and consumers three slots behind need no action. The opcode values of the five classes and all field widths are parameters.

Instruction bits are numbered from the most significant end: bits 0..5 hold the opcode, bits 6..10 hold the first source field and bits 11..15 hold the second field. With the default 32-bit word these are `[31:26]`, `[25:21]` and `[20:16]`.

Top module: `lu_interlock`

## Requirements
- R1: A stall is raised only while the execute slot holds a load, meaning its opcode (bits 0..5, `[31:26]`) equals `OP_LOAD`. Any other producer never stalls.
- R2: When the decode slot holds a register-register op, ALU-immediate op, load, store or branch, the unit stalls if the decode word's first source field (`[25:21]`) equals the load destination (`[20:16]` of the execute word).
- R3: A match between the decode word's second field (`[20:16]`) and the load destination stalls only when the decode slot holds a register-register op. For the other four classes that field is ignored.
- R4: A load whose destination is register 0 never causes a stall.
- R5: In the cycle after a stall, the execute slot holds the all-zero word.
- R6: While `stall` is high, `pc_hold`, `ifid_hold` and `idex_bubble` are high. In the next cycle the decode slot still holds the same word and the fetched word is dropped.
- R7: Without a stall, the decode slot takes the fetched word and the execute slot takes the previous decode word. A consumer two slots behind a load does not stall.
- R8: A stall never lasts more than one cycle for a given load-use pair.
- R9: An opcode outside the five classes reads no register and never stalls.
- R10: After reset both slots hold zero and every stall output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low reset, applied synchronously to the pipeline registers |
| fetch_instr | input | XLEN | Instruction word delivered by fetch this cycle |
| ifid_instr | output | XLEN | Instruction word in the decode slot |
| idex_instr | output | XLEN | Instruction word in the execute slot |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Decode slot reloads its own contents |
| idex_bubble | output | 1 | Execute slot is loaded with the zero word |

## Verification
Two things can fall in the same cycle and must be told apart. One is the end of a stall, when the bubble enters execute and the held consumer is offered again. The other is a fresh hazard between that consumer and a load that followed it. This is provoked by a load whose consumer is itself a load, which is in turn followed by its own consumer. It is also provoked by re-presenting the consumer word on fetch while the stall is in effect. A reference model checks that the second stall, if one is due, starts only after the bubble has passed, and that the word fetched during the stall never reaches the decode slot.

// File: rtl/lu_pkg.sv
package lu_pkg;

   // Consumer classes; each decides which source fields are read.
   typedef enum logic [2:0] {
      CLS_NONE   = 3'd0,
      CLS_RR     = 3'd1,
      CLS_ALUI   = 3'd2,
      CLS_LOAD   = 3'd3,
      CLS_STORE  = 3'd4,
      CLS_BRANCH = 3'd5
   } op_class_e;

   // Number of source-field lanes compared per consumer.
   localparam int unsigned LANES = 2;

   // Does class c read the first source field?
   function automatic logic reads_first(op_class_e c);
      return (c != CLS_NONE);
   endfunction

   // Does class c read the second field as a source?
   function automatic logic reads_second(op_class_e c);
      return (c == CLS_RR);
   endfunction

endpackage

// File: rtl/lu_decode.sv
module lu_decode
   import lu_pkg::*;
#(
   parameter int unsigned       OPC_W     = 6,
   parameter logic [OPC_W-1:0]  OP_RR     = 6'h00,
   parameter logic [OPC_W-1:0]  OP_ALUI   = 6'h08,
   parameter logic [OPC_W-1:0]  OP_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0]  OP_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0]  OP_BRANCH = 6'h04
) (
   input  logic [OPC_W-1:0] opcode,
   output op_class_e        cls
);

   always_comb begin
      if (opcode == OP_RR)          cls = CLS_RR;
      else if (opcode == OP_ALUI)   cls = CLS_ALUI;
      else if (opcode == OP_LOAD)   cls = CLS_LOAD;
      else if (opcode == OP_STORE)  cls = CLS_STORE;
      else if (opcode == OP_BRANCH) cls = CLS_BRANCH;
      else                          cls = CLS_NONE;
   end

endmodule

// File: rtl/lu_field_cmp.sv
module lu_field_cmp #(
   parameter int unsigned REG_W     = 5,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input  logic             enable,
   input  logic [REG_W-1:0] dest,
   input  logic [REG_W-1:0] src,
   output logic             hit
);

   logic same;
   assign same = (dest == src);

   generate
      if (SKIP_ZERO) begin : g_skip_zero
         // Register 0 is hard-wired; a write to it creates no dependence.
         assign hit = enable && same && (dest != '0);
      end else begin : g_plain
         assign hit = enable && same;
      end
   endgenerate

endmodule

// File: rtl/lu_stage_regs.sv
module lu_stage_regs #(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            freeze,
   input  logic [XLEN-1:0] fetch_word,
   output logic [XLEN-1:0] dec_word,
   output logic [XLEN-1:0] exe_word
);

   localparam logic [XLEN-1:0] BUBBLE = '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_word <= '0;
         exe_word <= BUBBLE;
      end else if (freeze) begin
         dec_word <= dec_word;
         exe_word <= BUBBLE;
      end else begin
         dec_word <= fetch_word;
         exe_word <= dec_word;
      end
   end

endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
   import lu_pkg::*;
#(
   parameter int unsigned       XLEN      = 32,
   parameter int unsigned       OPC_W     = 6,
   parameter int unsigned       REG_W     = 5,
   parameter bit                SKIP_ZERO = 1'b1,
   parameter logic [OPC_W-1:0]  OP_RR     = 6'h00,
   parameter logic [OPC_W-1:0]  OP_ALUI   = 6'h08,
   parameter logic [OPC_W-1:0]  OP_LOAD   = 6'h23,
   parameter logic [OPC_W-1:0]  OP_STORE  = 6'h2B,
   parameter logic [OPC_W-1:0]  OP_BRANCH = 6'h04
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] fetch_instr,
   output logic [XLEN-1:0] ifid_instr,
   output logic [XLEN-1:0] idex_instr,
   output logic            stall,
   output logic            pc_hold,
   output logic            ifid_hold,
   output logic            idex_bubble
);

   // Fields counted from the most significant end of the word.
   localparam int unsigned OPC_LO  = XLEN - OPC_W;
   localparam int unsigned SRC1_LO = OPC_LO - REG_W;
   localparam int unsigned SRC2_LO = SRC1_LO - REG_W;

   generate
      if (OPC_W + 2 * REG_W > XLEN) begin : g_bad_width
         $error("lu_interlock: opcode and two register fields exceed XLEN");
      end
      if (OP_RR == OP_ALUI || OP_RR == OP_LOAD || OP_RR == OP_STORE ||
          OP_RR == OP_BRANCH || OP_ALUI == OP_LOAD || OP_ALUI == OP_STORE ||
          OP_ALUI == OP_BRANCH || OP_LOAD == OP_STORE ||
          OP_LOAD == OP_BRANCH || OP_STORE == OP_BRANCH) begin : g_bad_opc
         $error("lu_interlock: class opcodes must be distinct");
      end
      if (OP_LOAD == '0) begin : g_bad_load
         $error("lu_interlock: the zero word must not decode as a load");
      end
   endgenerate

   logic [XLEN-1:0] dec_q, exe_q;
   op_class_e       cons_cls, prod_cls;
   logic            prod_is_load;
   logic [REG_W-1:0] load_dest;
   logic [REG_W-1:0] lane_src [LANES];
   logic [LANES-1:0] lane_en;
   logic [LANES-1:0] lane_hit;
   logic             hazard;

   lu_stage_regs #(.XLEN(XLEN)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze     (hazard),
      .fetch_word (fetch_instr),
      .dec_word   (dec_q),
      .exe_word   (exe_q)
   );

   lu_decode #(
      .OPC_W(OPC_W), .OP_RR(OP_RR), .OP_ALUI(OP_ALUI), .OP_LOAD(OP_LOAD),
      .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
   ) u_cons_dec (
      .opcode (dec_q[XLEN-1:OPC_LO]),
      .cls    (cons_cls)
   );

   lu_decode #(
      .OPC_W(OPC_W), .OP_RR(OP_RR), .OP_ALUI(OP_ALUI), .OP_LOAD(OP_LOAD),
      .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
   ) u_prod_dec (
      .opcode (exe_q[XLEN-1:OPC_LO]),
      .cls    (prod_cls)
   );

   assign prod_is_load = (prod_cls == CLS_LOAD);
   assign load_dest    = exe_q[SRC1_LO-1:SRC2_LO];

   assign lane_src[0] = dec_q[OPC_LO-1:SRC1_LO];
   assign lane_src[1] = dec_q[SRC1_LO-1:SRC2_LO];
   assign lane_en[0]  = reads_first(cons_cls);
   assign lane_en[1]  = reads_second(cons_cls);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         lu_field_cmp #(.REG_W(REG_W), .SKIP_ZERO(SKIP_ZERO)) u_cmp (
            .enable (lane_en[g] && prod_is_load),
            .dest   (load_dest),
            .src    (lane_src[g]),
            .hit    (lane_hit[g])
         );
      end
   endgenerate

   assign hazard      = |lane_hit;
   assign stall       = hazard;
   assign pc_hold     = hazard;
   assign ifid_hold   = hazard;
   assign idex_bubble = hazard;
   assign ifid_instr  = dec_q;
   assign idex_instr  = exe_q;

endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
   parameter int unsigned       XLEN    = 32,
   parameter int unsigned       OPC_W   = 6,
   parameter int unsigned       REG_W   = 5,
   parameter logic [OPC_W-1:0]  OP_LOAD = 6'h23
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] fetch_instr,
   input logic [XLEN-1:0] ifid_instr,
   input logic [XLEN-1:0] idex_instr,
   input logic            stall,
   input logic            pc_hold,
   input logic            ifid_hold,
   input logic            idex_bubble
);

   localparam int unsigned OPC_LO  = XLEN - OPC_W;
   localparam int unsigned SRC2_LO = OPC_LO - 2 * REG_W;

   p_only_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_instr[XLEN-1:OPC_LO] != OP_LOAD) |-> !stall);

   p_zero_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idex_instr[SRC2_LO+REG_W-1:SRC2_LO] == '0) |-> !stall);

   p_bubble_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (idex_instr == '0));

   p_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (pc_hold && ifid_hold && idex_bubble));

   p_dec_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(ifid_instr));

   p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> (ifid_instr == $past(fetch_instr)) &&
                 (idex_instr == $past(ifid_instr)));

   p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

endmodule

bind lu_interlock lu_interlock_chk #(
   .XLEN(XLEN), .OPC_W(OPC_W), .REG_W(REG_W), .OP_LOAD(OP_LOAD)
) u_lu_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_instr (fetch_instr),
   .ifid_instr  (ifid_instr),
   .idex_instr  (idex_instr),
   .stall       (stall),
   .pc_hold     (pc_hold),
   .ifid_hold   (ifid_hold),
   .idex_bubble (idex_bubble)
);

// File: tb/lu_interlock_test.sv
`timescale 1ns/1ps
module lu_interlock_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_instr = '0;
   logic [31:0] ifid_instr, idex_instr;
   logic        stall, pc_hold, ifid_hold, idex_bubble;

   int checks = 0;
   int fails  = 0;

   // Reference state
   logic [31:0] m_ifid = '0;
   logic [31:0] m_idex = '0;
   logic        m_stall = 1'b0;

   always #2.5 clk = ~clk;

   lu_interlock uut (
      .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
      .ifid_instr(ifid_instr), .idex_instr(idex_instr), .stall(stall),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
   );

   // class index: 0 rr, 1 alui, 2 load, 3 store, 4 branch, 5 other
   function automatic logic [5:0] opc_of(int k);
      case (k)
         0: return 6'h00;
         1: return 6'h08;
         2: return 6'h23;
         3: return 6'h2B;
         4: return 6'h04;
         default: return 6'h3F;
      endcase
   endfunction

   function automatic logic [31:0] mk(int k, int a, int b);
      return {opc_of(k), a[4:0], b[4:0], 16'h5A3C};
   endfunction

   function automatic logic want_stall(logic [31:0] dec, logic [31:0] exe);
      int d;
      int op;
      bit first, second;
      if (exe[31:26] != 6'h23) return 1'b0;
      d = int'(exe[20:16]);
      if (d == 0) return 1'b0;
      op = int'(dec[31:26]);
      first  = (op == 'h00 || op == 'h08 || op == 'h23 || op == 'h2B || op == 'h04);
      second = (op == 'h00);
      return (first && int'(dec[25:21]) == d) || (second && int'(dec[20:16]) == d);
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string stag, string itag, string etag);
      chk(stag, "stall", {31'd0, stall}, {31'd0, m_stall});
      chk("R6", "pc_hold", {31'd0, pc_hold}, {31'd0, m_stall});
      chk("R6", "ifid_hold", {31'd0, ifid_hold}, {31'd0, m_stall});
      chk("R6", "idex_bubble", {31'd0, idex_bubble}, {31'd0, m_stall});
      chk(itag, "ifid_instr", ifid_instr, m_ifid);
      chk(etag, "idex_instr", idex_instr, m_idex);
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(logic [31:0] ins, string tag);
      bit prev;
      fetch_instr = ins;
      @(posedge clk);
      #1;
      prev = m_stall;
      if (m_stall) begin
         m_idex = '0;
      end else begin
         m_idex = m_ifid;
         m_ifid = ins;
      end
      m_stall = want_stall(m_ifid, m_idex);
      @(negedge clk);
      compare_all(prev ? "R8" : tag, prev ? "R6" : "R7", prev ? "R5" : "R7");
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(32'h0, "R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare_all("R10", "R10", "R10");
      rst_n = 1'b1;

      // All producer/consumer class pairings, with dependence through
      // the first field, the second field, or none.
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < 6; c++) begin
            for (int dep = 0; dep < 3; dep++) begin
               string tag;
               logic [31:0] cons;
               if (p != 2)           tag = "R1";
               else if (c == 5)      tag = "R9";
               else if (dep == 2)    tag = "R3";
               else                  tag = "R2";
               cons = mk(c, (dep == 1) ? 7 : 3, (dep == 2) ? 7 : 4);
               step(mk(p, 5, 7), tag);
               step(cons, tag);
               step(cons, tag);   // re-presented while a stall may be in effect
               flush();
            end
         end
      end

      // Destination register 0 never stalls
      step(mk(2, 1, 0), "R4");
      step(mk(0, 0, 0), "R4");
      flush();

      // Consumer two slots behind: no stall
      step(mk(2, 1, 9), "R7");
      step(32'h0, "R7");
      step(mk(0, 9, 9), "R7");
      flush();

      // Chain: load -> dependent load -> dependent rr op
      step(mk(2, 1, 6), "R2");
      step(mk(2, 6, 8), "R2");
      step(mk(2, 6, 8), "R2");
      step(mk(0, 2, 8), "R3");
      step(mk(0, 2, 8), "R3");
      step(mk(0, 2, 8), "R3");
      flush();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule